// File: doc/BRIEF.md
# Trapezoid-Windowed Bitstream Sample Accumulator

This block takes the one-bit output of a free-running sigma-delta modulator and turns it into a stream of discrete multi-bit samples. It marks off windows of a fixed number of enabled clocks, back to back, on the bitstream. It never starts, stops or resynchronises the modulator. Inside each window every 1 bit adds a weight to a running total. The weight climbs linearly over the first few bits, stays flat through the body and falls linearly over the last few bits. Because the window opens and closes softly, the short repeating patterns a modulator produces no longer dither the low bits of the result at the window edges.

With taper length T, the flat weight is T. The bit at ramp-up step k (k = 1..T) weighs k, and the bit at ramp-down step k weighs T+1-k. When a window closes, the block presents the total divided by T, rounded down, and raises a one-cycle strobe with it. The default build uses a 6,176-bit window with a 32-bit taper, which is 6,144 effective bit times plus 32 for the two ramps. A 16-bit taper on a longer window is just another parameter setting.

Top module: `tap_win_acc`

## Requirements
- R1: A synchronous active-high reset clears the output word to 0 and the strobe to 0. It discards any partial window, and the next window starts on the first enabled clock after reset.
- R2: The enabled bit at window position p, for p from 0 to T-1, weighs p+1.
- R3: The enabled bit at position p, for T <= p < WIN_LEN-T, weighs T.
- R4: The enabled bit at position p, for WIN_LEN-T <= p < WIN_LEN, weighs WIN_LEN-p.
- R5: `valid_o` goes high for exactly one cycle after every WIN_LEN enabled clocks. The next window begins at the very next enabled clock, so no bit is skipped or counted twice.
- R6: At the strobe, `sample_o` equals the weighted total of the window shifted right by log2(T), which is floor division by T. It holds that value until the next strobe.
- R7: On a clock with `en_i` low, the bit input is ignored and the window position does not advance.
- R8: A window of all ones gives WIN_LEN-T+1 with no overflow, and no output ever exceeds that value.
- R9: A window of all zeros gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Bit qualifier; when low the clock is not part of any window |
| adc_bit_i | input | 1 | Modulator output bit |
| sample_o | output | OUT_W | Finished sample, weighted total / T |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench builds a small 40-bit window with an 8-bit taper and probes each ramp by growing runs of ones from either end. A weight misplaced by one position, or a ramp running the wrong way, shows up as a wrong sample code. Flat-body runs and the all-ones and all-zeros windows catch a body weight that is not T and an accumulator too narrow for the worst case. A sweep over all 256 levels of an 8-bit phase-accumulator modulator runs windows back to back. This exposes an off-by-one window length, a dropped or doubled boundary bit, and a strobe that lasts too long. Windows with disabled gaps fed with ones, and a reset in mid-window, catch a design that counts idle bits or carries stale partial sums forward.

// File: rtl/tapwin_pkg.sv
package tapwin_pkg;

  // Largest weighted total of a window of all ones: T*(W-2T) + T*(T+1)
  function automatic int unsigned peak_total(int unsigned win, int unsigned tap);
    return tap * (win - tap + 1);
  endfunction

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/twa_pos_ctr.sv
module twa_pos_ctr #(
  parameter int WIN_LEN = 6176,
  parameter int POS_W   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

  assign last_o = (pos_o == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o <= '0;
    end else if (en_i) begin
      pos_o <= last_o ? '0 : pos_o + POS_W'(1);
    end
  end
endmodule

// File: rtl/twa_weight.sv
module twa_weight #(
  parameter int WIN_LEN = 6176,
  parameter int TAPER   = 32,
  parameter int POS_W   = 13,
  parameter int WT_W    = 6
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [WT_W-1:0]  wt_o
);
  localparam logic [POS_W-1:0] RISE_END  = POS_W'(TAPER);
  localparam logic [POS_W-1:0] FALL_BEG  = POS_W'(WIN_LEN - TAPER);
  localparam logic [POS_W-1:0] WIN_SZ    = POS_W'(WIN_LEN);
  localparam logic [WT_W-1:0]  FLAT_WT   = WT_W'(TAPER);

  logic [POS_W-1:0] rise_wt, fall_wt;

  assign rise_wt = pos_i + POS_W'(1);
  assign fall_wt = WIN_SZ - pos_i;

  always_comb begin
    if (pos_i < RISE_END)       wt_o = WT_W'(rise_wt);
    else if (pos_i >= FALL_BEG) wt_o = WT_W'(fall_wt);
    else                        wt_o = FLAT_WT;
  end
endmodule

// File: rtl/twa_accum.sv
module twa_accum #(
  parameter int ACC_W = 18,
  parameter int WT_W  = 6,
  parameter int SH    = 5,
  parameter int OUT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic             last_i,
  input  logic [WT_W-1:0]  wt_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] sum;

  assign addend = bit_i ? ACC_W'(wt_i) : '0;
  assign sum    = acc_q + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= en_i && last_i;
      if (en_i) begin
        if (last_i) begin
          acc_q    <= '0;
          sample_o <= sum[SH +: OUT_W];
        end else begin
          acc_q <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/tap_win_acc.sv
module tap_win_acc #(
  parameter  int WIN_LEN = 6176,
  parameter  int TAPER   = 32,
  localparam int OUT_W   = $clog2(WIN_LEN - TAPER + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             adc_bit_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int POS_W = $clog2(WIN_LEN);
  localparam int WT_W  = $clog2(TAPER + 1);
  localparam int ACC_W = $clog2(tapwin_pkg::peak_total(WIN_LEN, TAPER) + 1);
  localparam int SH    = $clog2(TAPER);

  if (2 * TAPER >= WIN_LEN) begin : g_bad_len
    $error("taper must be shorter than half the window");
  end
  if (!tapwin_pkg::is_pow2(TAPER)) begin : g_bad_tap
    $error("taper length must be a power of two");
  end

  logic [POS_W-1:0] pos;
  logic             last;
  logic [WT_W-1:0]  wt;

  twa_pos_ctr #(.WIN_LEN(WIN_LEN), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .en_i(en_i), .pos_o(pos), .last_o(last)
  );

  twa_weight #(.WIN_LEN(WIN_LEN), .TAPER(TAPER), .POS_W(POS_W), .WT_W(WT_W)) u_wt (
    .pos_i(pos), .wt_o(wt)
  );

  twa_accum #(.ACC_W(ACC_W), .WT_W(WT_W), .SH(SH), .OUT_W(OUT_W)) u_acc (
    .clk(clk), .rst(rst), .en_i(en_i), .bit_i(adc_bit_i), .last_i(last),
    .wt_i(wt), .sample_o(sample_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/tap_win_acc_chk.sv
module tap_win_acc_chk #(
  parameter  int WIN_LEN = 6176,
  parameter  int TAPER   = 32,
  localparam int OUT_W   = $clog2(WIN_LEN - TAPER + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             adc_bit_i,
  input logic [OUT_W-1:0] sample_o,
  input logic             valid_o
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0] en_cnt;

  always_ff @(posedge clk) begin
    if (rst) en_cnt <= '0;
    else     en_cnt <= (valid_o ? '0 : en_cnt) + CNT_W'(en_i);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && sample_o == '0)); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_WINDOW_SPACING: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (en_cnt == CNT_W'(WIN_LEN))); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    en_cnt <= CNT_W'(WIN_LEN)); // R5
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sample_o)); // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(en_i)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(sample_o) <= WIN_LEN - TAPER + 1); // R8
endmodule

bind tap_win_acc tap_win_acc_chk #(.WIN_LEN(WIN_LEN), .TAPER(TAPER)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .adc_bit_i(adc_bit_i),
  .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/tap_win_acc_tb.sv
module tap_win_acc_tb;
  localparam int W  = 40;
  localparam int T  = 8;
  localparam int SH = 3;
  localparam int OW = $clog2(W - T + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic bit_in = 1'b0;
  logic [OW-1:0] sample;
  logic valid;

  always #4 clk = ~clk;

  tap_win_acc #(.WIN_LEN(W), .TAPER(T)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .adc_bit_i(bit_in),
    .sample_o(sample), .valid_o(valid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int pend = -1;
  string pend_req = "";
  int bpos = 0;
  int bsum = 0;
  logic [7:0] pacc = 8'd0;
  bit done = 0;

  function automatic int wt(int p);
    if (p < T) return p + 1;
    if (p >= W - T) return W - p;
    return T;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: check the outputs of the previous edge, then drive new inputs
  task automatic step(bit e, bit b, string req);
    @(negedge clk);
    if (pend >= 0) begin
      chk(valid === 1'b1, "R5 strobe", int'(valid), 1);
      chk(int'(sample) == pend, pend_req, int'(sample), pend);
      pend = -1;
    end else begin
      chk(valid === 1'b0, "R5 no strobe", int'(valid), 0);
    end
    en = e;
    bit_in = b;
    if (e) begin
      bsum += (b ? wt(bpos) : 0);
      if (bpos == W - 1) begin
        pend = bsum >> SH;
        pend_req = req;
        bsum = 0;
        bpos = 0;
      end else begin
        bpos++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; en = 1'b0; bit_in = 1'b0;
    bpos = 0; bsum = 0; pend = -1;
    chk(valid === 1'b0, "R1 strobe", int'(valid), 0);
    chk(int'(sample) == 0, "R1 sample", int'(sample), 0);
  endtask

  task automatic feed(logic [W-1:0] pat, string req);
    for (int i = 0; i < W; i++) step(1'b1, pat[i], req);
  endtask

  task automatic feed_gappy(logic [W-1:0] pat, string req);
    for (int i = 0; i < W; i++) begin
      step(1'b0, 1'b1, req);          // R7: ones while disabled
      step(1'b1, pat[i], req);
    end
  endtask

  task automatic dsm_window(logic [7:0] lvl, string req);
    for (int i = 0; i < W; i++) begin
      logic [8:0] s;
      s = {1'b0, pacc} + {1'b0, lvl};
      pacc = s[7:0];
      step(1'b1, s[8], req);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    do_reset();                                   // R1
    step(1'b0, 1'b0, "R1");
    feed('1, "R8 all ones");                      // expect 33
    feed('0, "R9 all zeros");
    // R2: growing runs of ones from the window start
    for (int k = 0; k < T + 2; k++) begin
      pat = '0;
      for (int i = 0; i <= k; i++) pat[i] = 1'b1;
      feed(pat, "R2 leading ramp");
    end
    // R4: growing runs of ones ending at the window end
    for (int k = 0; k < T + 2; k++) begin
      pat = '0;
      for (int i = 0; i <= k; i++) pat[W-1-i] = 1'b1;
      feed(pat, "R4 trailing ramp");
    end
    // R3: runs in the flat body
    for (int n = 1; n <= W - 2 * T; n += 3) begin
      pat = '0;
      for (int i = 0; i < n; i++) pat[T+i] = 1'b1;
      feed(pat, "R3 flat body");
    end
    // R6: phase-accumulator modulator over every level, back to back
    for (int v = 0; v < 256; v++) dsm_window(8'(v), "R6 modulator sweep");
    // R7: disabled clocks with ones in between enabled bits
    feed_gappy({W/2{2'b01}}, "R7 gaps");
    feed_gappy('1, "R7 gaps all ones");
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    // R1: reset in the middle of a window
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, "R1");
    do_reset();
    feed({W/4{4'b0011}}, "R1 after mid reset");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, "R5");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule